// File: doc/BRIEF.md
# Clocked Eight-Way Bit Selector with Gated Complementary Outputs

This block picks one bit out of eight and presents it on a true output and an inverted output. The eight input bits are first stored together in a data register on the rising clock edge. A three-bit select code then chooses which stored bit reaches the outputs. The select code passes through a level-sensitive hold stage. While `sel_hold` is low that stage is transparent. While `sel_hold` is high it keeps the last code it saw.

Three enable inputs decide whether the outputs drive. Two of them are active low and one is active high. The block does not use tri-state logic internally. Instead, a drive flag tells the pad ring when to drive. Whenever that flag is low, both data outputs are held at 0.

Top module: `mux_reg_sel`

## Requirements
- R1: The select code is an unsigned binary number. Code k (0 to 7) routes stored bit k of the data register to `y`.
- R2: On each rising edge of `clk` with `rst` low, all eight bits of `din` are copied into the data register together.
- R3: A change on `din` between two rising edges has no effect on `y` or `y_n` until the next rising edge.
- R4: While `sel_hold` is low, a change on `sel` moves the selection at once, with no clock edge needed.
- R5: While `sel_hold` is high, the selection keeps the code that was present when `sel_hold` was last low, and changes on `sel` are ignored.
- R6: `out_drive` is 1 only when `oe_a_n` = 0, `oe_b_n` = 0 and `oe_c` = 1. It is 0 for the other seven combinations.
- R7: While `out_drive` is 0, `y` and `y_n` are both 0.
- R8: While `out_drive` is 1, `y_n` is the inverse of `y`.
- R9: A rising edge with `rst` high clears the data register to all zeros. While `rst` is high, the held select code is forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data is captured on the rising edge |
| rst | input | 1 | Active-high reset |
| din | input | 8 | Parallel data bits to capture |
| sel | input | 3 | Binary select code |
| sel_hold | input | 1 | 1 holds the select code; 0 lets it pass through |
| oe_a_n | input | 1 | Active-low output enable |
| oe_b_n | input | 1 | Active-low output enable |
| oe_c | input | 1 | Active-high output enable |
| y | output | 1 | Selected stored bit, 0 when not driving |
| y_n | output | 1 | Inverse of the selected bit, 0 when not driving |
| out_drive | output | 1 | 1 when the outputs should be driven |

## Verification
The assertions check four rules on every clock cycle:
- the register captures `din` on each edge;
- the held select code stays stable while `sel_hold` remains high;
- a driving output equals the addressed stored bit, and `y_n` is its inverse;
- both outputs are 0 while `out_drive` is low.

Some behaviour falls between clock edges, so only the bench scenarios can show it. These are the immediate effect of `sel` while `sel_hold` is low, and the fact that late changes on `din` stay off the outputs until the next edge. The bench also covers the full sweep over all select codes and all eight enable combinations, each compared against arithmetic expectations.

// File: rtl/mux_reg_sel_pkg.sv
package mux_reg_sel_pkg;

    localparam int NUM_IN = 8;
    localparam int ADDR_W = $clog2(NUM_IN);

    typedef logic [NUM_IN-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic a_n;
        logic b_n;
        logic c;
    } enables_t;

    typedef struct packed {
        logic drive;
        logic val;
        logic val_n;
    } outs_t;

    function automatic logic enables_on(enables_t e);
        return (~e.a_n) & (~e.b_n) & e.c;
    endfunction

endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= d[i];
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == $past(d));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == '0);

endmodule

// File: rtl/addr_hold.sv
module addr_hold #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [AW-1:0] a,
    output logic [AW-1:0] q
);

    always_latch begin
        if (rst)        q <= '0;
        else if (!hold) q <= a;
    end

    assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && !$past(rst)) |-> $stable(q));

endmodule

// File: rtl/bit_pick.sv
module bit_pick
    import mux_reg_sel_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] addr,
    input  enables_t      en,
    output outs_t         o
);

    logic [W-1:0] hit;
    logic         bit_sel;
    logic         drv;

    for (genvar k = 0; k < W; k++) begin : g_dec
        assign hit[k] = (addr == AW'(k)) & data[k];
    end

    always_comb begin
        bit_sel = |hit;
        drv     = enables_on(en);
        o.drive = drv;
        o.val   = drv & bit_sel;
        o.val_n = drv & ~bit_sel;
    end

endmodule

// File: rtl/mux_reg_sel.sv
module mux_reg_sel
    import mux_reg_sel_pkg::*;
#(
    parameter int N_IN = NUM_IN,
    localparam int AW  = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] din,
    input  logic [AW-1:0]   sel,
    input  logic            sel_hold,
    input  logic            oe_a_n,
    input  logic            oe_b_n,
    input  logic            oe_c,
    output logic            y,
    output logic            y_n,
    output logic            out_drive
);

    logic [N_IN-1:0] data_q;
    logic [AW-1:0]   addr_q;
    enables_t        en;
    outs_t           res;

    capture_reg #(.W(N_IN)) u_data (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (data_q)
    );

    addr_hold #(.AW(AW)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .hold (sel_hold),
        .a    (sel),
        .q    (addr_q)
    );

    always_comb begin
        en.a_n = oe_a_n;
        en.b_n = oe_b_n;
        en.c   = oe_c;
    end

    bit_pick #(.W(N_IN), .AW(AW)) u_pick (
        .data (data_q),
        .addr (addr_q),
        .en   (en),
        .o    (res)
    );

    assign y         = res.val;
    assign y_n       = res.val_n;
    assign out_drive = res.drive;

    assert_pick_R1: assert property (@(posedge clk) disable iff (rst)
        out_drive |-> y == data_q[addr_q]);

    assert_drive_R6: assert property (@(posedge clk) disable iff (rst)
        out_drive |-> (!oe_a_n && !oe_b_n && oe_c));

    assert_dark_R7: assert property (@(posedge clk) disable iff (rst)
        !out_drive |-> (!y && !y_n));

    assert_compl_R8: assert property (@(posedge clk) disable iff (rst)
        out_drive |-> (y_n != y));

endmodule

// File: tb/sim_mux_reg_sel.sv
`timescale 1ns/1ps
module sim_mux_reg_sel;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic [2:0] sel = '0;
    logic       sel_hold = 1'b0;
    logic       oe_a_n = 1'b0;
    logic       oe_b_n = 1'b0;
    logic       oe_c = 1'b1;
    logic       y, y_n, out_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_reg_sel u0 (
        .clk(clk), .rst(rst), .din(din), .sel(sel), .sel_hold(sel_hold),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c(oe_c),
        .y(y), .y_n(y_n), .out_drive(out_drive)
    );

    task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {y,y_n,drive} got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic capture(logic [7:0] v);
        @(negedge clk);
        din = v;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [5];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h01;
        pats[3] = 8'h80; pats[4] = 8'hFF;

        // R9: reset with a non-zero select held; data cleared, address forced to 0
        sel_hold = 1'b1; sel = 3'd5; din = 8'hFF;
        repeat (2) @(negedge clk);
        #1 chk("R9", {y, y_n, out_drive}, 3'b011);
        rst = 1'b0;
        din = 8'h01;
        @(negedge clk); #1;
        // held address must still be 0 after reset, bit0 = 1
        chk("R9", {y, y_n, out_drive}, 3'b101);
        sel_hold = 1'b0;

        // R1 R2 R4: sweep all addresses over several patterns
        foreach (pats[p]) begin
            capture(pats[p]);
            for (int a = 0; a < 8; a++) begin
                sel = 3'(a);
                #1 chk("R1", {y, y_n, out_drive}, {pats[p][a], ~pats[p][a], 1'b1});
            end
        end
        // R2: walking one captured, every bit checked
        for (int k = 0; k < 8; k++) begin
            capture(8'(1 << k));
            for (int a = 0; a < 8; a++) begin
                sel = 3'(a);
                #1 chk("R2", {y, y_n, out_drive}, {1'(a == k), 1'(a != k), 1'b1});
            end
        end

        // R3: data changed just after an edge stays off the outputs until the next edge
        capture(8'h5A);
        @(posedge clk); #1 din = 8'hA5;
        for (int a = 0; a < 8; a++) begin
            sel = 3'(a);
            #0.5 chk("R3", {y, y_n, out_drive}, {1'(8'h5A >> a), ~1'(8'h5A >> a), 1'b1});
        end
        @(posedge clk); #1;
        for (int a = 0; a < 8; a++) begin
            sel = 3'(a);
            #0.5 chk("R3", {y, y_n, out_drive}, {1'(8'hA5 >> a), ~1'(8'hA5 >> a), 1'b1});
        end

        // R5: hold address 2, then move sel; output stays on bit 2
        capture(8'b0000_0100);
        sel = 3'd2; #1 sel_hold = 1'b1;
        for (int a = 0; a < 8; a++) begin
            sel = 3'(a);
            #1 chk("R5", {y, y_n, out_drive}, 3'b101);
        end
        @(negedge clk); #1 chk("R5", {y, y_n, out_drive}, 3'b101);
        sel = 3'd6; sel_hold = 1'b0;
        #1 chk("R4", {y, y_n, out_drive}, 3'b011);

        // R6 R7 R8: all enable combinations, two selected values
        capture(8'b0100_0001);
        for (int v = 0; v < 2; v++) begin
            sel = v == 0 ? 3'd0 : 3'd1;
            for (int e = 0; e < 8; e++) begin
                logic on, b;
                {oe_a_n, oe_b_n, oe_c} = 3'(e);
                on = (e == 1);
                b  = (v == 0);
                #1 chk(on ? "R8" : "R7", {y, y_n, out_drive}, {on & b, on & ~b, on});
                chk("R6", {2'b00, out_drive}, {2'b00, on});
            end
        end
        {oe_a_n, oe_b_n, oe_c} = 3'b001;

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule